// File: doc/BRIEF.md
# Fly-By Peripheral-to-Memory DMA Channel

This block is a single DMA channel that moves data from an I/O peripheral into memory, one item per request, with no help from the processor. It is loaded with a start address and a transfer count. When the peripheral raises its request and the channel is not masked, the block asks the processor for the bus. It then waits for the processor to grant the bus before it drives anything. Once the bus is granted, it puts the current memory address out and acknowledges the peripheral. It pulses the memory-write and I/O-read strobes together, so the peripheral's data goes straight into memory in a single fly-by cycle. After that it hands the bus back.

After each completed transfer the address steps up by one and the count steps down by one. When a transfer is made with the count at zero, the count wraps and a terminal-count flag is set. The channel then stays stopped until it is loaded again. If the processor takes back its grant partway through a transfer, the channel drops everything and returns to idle without touching its address or count. The address, the acknowledge and the strobes are only valid while `bus_oe` is high. When it is low, the address reads zero and the strobes read inactive, which stands in for a floated bus.

Top module: `dma_fly_ch`

## Requirements
- R1: After reset, `hold_req_out`, `ack_out` and `bus_oe` are 0, `mem_wr_n` and `io_rd_n` are 1, `tc_out` is 0 and `addr_out` reads 0.
- R2: While `mask_in` is 1, a high `req_in` never raises `hold_req_out`. In idle, an unmasked `req_in` raises `hold_req_out` on the next clock edge, provided `hold_ack_in` is low.
- R3: While `hold_ack_in` is low, `ack_out` and `bus_oe` stay 0 and both strobes stay 1, even when `hold_req_out` is 1.
- R4: The first edge that samples `hold_ack_in` high with `hold_req_out` up makes `bus_oe` and `ack_out` 1 and drives `addr_out` with the current address. This setup cycle has both strobes at 1 and lasts exactly one clock.
- R5: After the setup cycle, `mem_wr_n` and `io_rd_n` go low together and stay low for exactly STB_CYC clocks (default 2).
- R6: After the strobes rise, `ack_out`, `bus_oe` and `hold_req_out` stay 1 for one more clock, then all drop together. A new request is only taken once `hold_ack_in` has returned low.
- R7: Each completed transfer raises the address by one, wrapping modulo 2^AW. It also lowers the count by one. A loaded count of N gives N+1 transfers.
- R8: A transfer completed with the count at 0 sets `tc_out`. The channel then ignores every request, keeping `hold_req_out` at 0, until the next load.
- R9: If `hold_ack_in` falls while the channel owns the bus, the next edge drops `ack_out`, `bus_oe` and both strobes. The address and count keep their values, so the next transfer reuses the same address.
- R10: `ld_en` loads `ld_addr` and `ld_cnt` and clears `tc_out` only when the channel is idle or stopped. A load while a transfer is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load start address and count |
| ld_addr | input | AW | Start address to load |
| ld_cnt | input | CW | Transfer count to load (N gives N+1 transfers) |
| req_in | input | 1 | Peripheral transfer request (level) |
| mask_in | input | 1 | Channel mask, 1 blocks requests |
| hold_ack_in | input | 1 | Processor grants the bus |
| hold_req_out | output | 1 | Bus request to the processor |
| ack_out | output | 1 | Acknowledge to the peripheral |
| bus_oe | output | 1 | Output enable for address, acknowledge and strobes |
| addr_out | output | AW | Memory address |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| tc_out | output | 1 | Terminal count reached, channel stopped |

## Verification
The assertions assume the processor behaves like a bus master. It raises `hold_ack_in` only in answer to `hold_req_out`, and it lowers `hold_ack_in` some time after `hold_req_out` falls. The bench models the processor as a half-cycle register that follows `hold_req_out`, so it never grants the bus unasked. Aborts and withheld grants come from a separate override that can only lower the grant, never raise it. The peripheral in the bench holds its request until it sees the acknowledge, then drops it, so every request gives exactly one transfer.

// File: rtl/dma_fly_pkg.sv
package dma_fly_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_SETUP = 3'd2,
    ST_STB   = 3'd3,
    ST_RECOV = 3'd4,
    ST_STOP  = 3'd5
  } dma_state_e;
endpackage

// File: rtl/dma_req_gate.sv
module dma_req_gate (
  input  logic req_in,
  input  logic mask_in,
  input  logic hold_ack_in,
  output logic start_ok
);
  // A new request is taken only when unmasked and the previous grant is gone
  always_comb begin
    start_ok = req_in & ~mask_in & ~hold_ack_in;
  end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm #(
  parameter int STB_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  input  logic hold_ack_in,
  input  logic ld_en,
  input  logic cnt_zero,
  output logic hrq,
  output logic own_bus,
  output logic strobe_act,
  output logic commit,
  output logic load_ok
);
  import dma_fly_pkg::*;

  localparam int SCW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;
  localparam logic [SCW-1:0] STB_LAST = SCW'(STB_CYC - 1);

  dma_state_e state_q, state_d;
  logic [SCW-1:0] stb_q, stb_d;
  logic stb_en;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    commit  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_ok) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (hold_ack_in) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        if (!hold_ack_in) state_d = ST_IDLE;
        else              state_d = ST_STB;
      end
      ST_STB: begin
        if (!hold_ack_in)          state_d = ST_IDLE;
        else if (stb_q == STB_LAST) state_d = ST_RECOV;
      end
      ST_RECOV: begin
        if (!hold_ack_in) begin
          state_d = ST_IDLE;
        end else begin
          commit  = 1'b1;
          state_d = cnt_zero ? ST_STOP : ST_IDLE;
        end
      end
      ST_STOP: begin
        if (ld_en) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Strobe width counter
  always_comb begin
    stb_en = 1'b0;
    stb_d  = stb_q;
    if (state_q == ST_SETUP) begin
      stb_en = 1'b1;
      stb_d  = '0;
    end else if (state_q == ST_STB) begin
      stb_en = 1'b1;
      stb_d  = stb_q + SCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
    end else if (stb_en) begin
      stb_q <= stb_d;
    end
  end

  // Moore outputs
  always_comb begin
    hrq        = (state_q == ST_HOLD) || (state_q == ST_SETUP) ||
                 (state_q == ST_STB)  || (state_q == ST_RECOV);
    own_bus    = (state_q == ST_SETUP) || (state_q == ST_STB) ||
                 (state_q == ST_RECOV);
    strobe_act = (state_q == ST_STB);
    load_ok    = (state_q == ST_IDLE) || (state_q == ST_STOP);
  end
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          load_ok,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  logic          commit,
  output logic [AW-1:0] addr_q,
  output logic          cnt_zero,
  output logic          tc_q
);
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_d;
  logic [CW-1:0] cnt_d;
  logic          tc_d;
  logic          reg_en;

  always_comb begin
    cnt_zero = (cnt_q == '0);
    reg_en   = 1'b0;
    addr_d   = addr_q;
    cnt_d    = cnt_q;
    tc_d     = tc_q;
    if (ld_en && load_ok) begin
      reg_en = 1'b1;
      addr_d = ld_addr;
      cnt_d  = ld_cnt;
      tc_d   = 1'b0;
    end else if (commit) begin
      reg_en = 1'b1;
      addr_d = addr_q + AW'(1);
      cnt_d  = cnt_q - CW'(1);
      tc_d   = cnt_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      tc_q   <= 1'b0;
    end else if (reg_en) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      tc_q   <= tc_d;
    end
  end
endmodule

// File: rtl/dma_fly_ch.sv
module dma_fly_ch #(
  parameter int AW      = 16,
  parameter int CW      = 16,
  parameter int STB_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  logic          req_in,
  input  logic          mask_in,
  input  logic          hold_ack_in,
  output logic          hold_req_out,
  output logic          ack_out,
  output logic          bus_oe,
  output logic [AW-1:0] addr_out,
  output logic          mem_wr_n,
  output logic          io_rd_n,
  output logic          tc_out
);
  logic start_ok, own_bus, strobe_act, commit, load_ok, cnt_zero, tc_q;
  logic [AW-1:0] addr_q;

  dma_req_gate u_gate (
    .req_in      (req_in),
    .mask_in     (mask_in),
    .hold_ack_in (hold_ack_in),
    .start_ok    (start_ok)
  );

  dma_seq_fsm #(.STB_CYC(STB_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_ok    (start_ok),
    .hold_ack_in (hold_ack_in),
    .ld_en       (ld_en),
    .cnt_zero    (cnt_zero),
    .hrq         (hold_req_out),
    .own_bus     (own_bus),
    .strobe_act  (strobe_act),
    .commit      (commit),
    .load_ok     (load_ok)
  );

  dma_xfer_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .load_ok  (load_ok),
    .ld_addr  (ld_addr),
    .ld_cnt   (ld_cnt),
    .commit   (commit),
    .addr_q   (addr_q),
    .cnt_zero (cnt_zero),
    .tc_q     (tc_q)
  );

  // Bus drivers: valid only while the channel owns the bus
  always_comb begin
    bus_oe   = own_bus;
    ack_out  = own_bus;
    addr_out = own_bus ? addr_q : '0;
    mem_wr_n = ~(own_bus & strobe_act);
    io_rd_n  = ~(own_bus & strobe_act);
    tc_out   = tc_q;
  end
endmodule

// File: rtl/dma_fly_ch_chk.sv
module dma_fly_ch_chk (
  input logic clk,
  input logic rst_n,
  input logic req_in,
  input logic mask_in,
  input logic hold_ack_in,
  input logic hold_req_out,
  input logic ack_out,
  input logic bus_oe,
  input logic mem_wr_n,
  input logic io_rd_n,
  input logic tc_out
);
  AST_MASK_BLOCKS_HRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req_out) |-> $past(req_in && !mask_in)); // R2

  AST_ACK_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_out) |-> $past(hold_ack_in && hold_req_out)); // R3

  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n || !io_rd_n) |-> (ack_out && bus_oe && hold_req_out)); // R4

  AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> $fell(io_rd_n)); // R5

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_wr_n) && $past(hold_ack_in)) |-> ($past(mem_wr_n, 2) == 1'b0)); // R5

  AST_ACK_DROPS_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_out) && $past(hold_ack_in)) |-> $past(mem_wr_n && io_rd_n)); // R6

  AST_STOPPED_NO_HRQ: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> !hold_req_out); // R8

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_out) && !$past(hold_ack_in)) |-> (!ack_out && mem_wr_n && io_rd_n)); // R9
endmodule

bind dma_fly_ch dma_fly_ch_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_in       (req_in),
  .mask_in      (mask_in),
  .hold_ack_in  (hold_ack_in),
  .hold_req_out (hold_req_out),
  .ack_out      (ack_out),
  .bus_oe       (bus_oe),
  .mem_wr_n     (mem_wr_n),
  .io_rd_n      (io_rd_n),
  .tc_out       (tc_out)
);

// File: tb/dma_fly_ch_tb.sv
module dma_fly_ch_tb;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk, rst_n, ld_en, req_in, mask_in, hold_ack_in;
  logic [AW-1:0] ld_addr, addr_out;
  logic [CW-1:0] ld_cnt;
  logic hold_req_out, ack_out, bus_oe, mem_wr_n, io_rd_n, tc_out;

  int n_chk, n_bad;
  logic [AW-1:0] exp_q[$];

  // Processor model: grants half a cycle after the request; drop forces release
  logic hlda_d, drop;
  assign hold_ack_in = hlda_d & ~drop;

  dma_fly_ch #(.AW(AW), .CW(CW), .STB_CYC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .req_in(req_in), .mask_in(mask_in), .hold_ack_in(hold_ack_in),
    .hold_req_out(hold_req_out), .ack_out(ack_out), .bus_oe(bus_oe),
    .addr_out(addr_out), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .tc_out(tc_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) hlda_d <= 1'b0;
    else        hlda_d <= hold_req_out;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops an expected address at each strobe start, checks width and release order
  logic stb_prev;
  int   stb_w;
  logic prev_own;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_wr_n && stb_prev) begin
        chk(prev_own, "R4 setup cycle before strobe", int'(prev_own), 1);
        chk(!io_rd_n, "R5 io_rd_n with mem_wr_n", int'(io_rd_n), 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected transfer", int'(addr_out), 0);
        end else begin
          logic [AW-1:0] e;
          e = exp_q.pop_front();
          chk(addr_out == e, "R7 transfer address", int'(addr_out), int'(e));
        end
        stb_w = 1;
      end else if (!mem_wr_n) begin
        stb_w++;
      end else if (!stb_prev) begin
        chk(stb_w == 2, "R5 strobe width", stb_w, 2);
        chk(ack_out && bus_oe && hold_req_out, "R6 ack held after strobe",
            int'({ack_out, bus_oe, hold_req_out}), 7);
      end
      stb_prev = mem_wr_n;
      prev_own = ack_out & bus_oe;
    end else begin
      stb_prev = 1'b1;
      prev_own = 1'b0;
      stb_w    = 0;
    end
  end

  task automatic load(input logic [AW-1:0] a, input logic [CW-1:0] c);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_cnt = c;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (hold_req_out || hold_ack_in);
  endtask

  // Driver: one request, one expected transfer
  task automatic xfer(input logic [AW-1:0] a);
    exp_q.push_back(a);
    @(negedge clk);
    req_in = 1'b1;
    do @(negedge clk); while (!ack_out);
    req_in = 1'b0;
    do @(negedge clk); while (ack_out);
    chk(!hold_req_out && !bus_oe, "R6 release together",
        int'({hold_req_out, bus_oe}), 0);
    wait_idle();
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_cnt = '0;
    req_in = 1'b0; mask_in = 1'b0; drop = 1'b0;
    repeat (3) @(negedge clk);
    chk(!hold_req_out && !ack_out && !bus_oe && mem_wr_n && io_rd_n && !tc_out
        && addr_out == 0, "R1 reset outputs",
        int'({hold_req_out, ack_out, bus_oe, mem_wr_n, io_rd_n, tc_out}), 'b000110);
    rst_n = 1'b1;
    @(negedge clk);

    // Count 2 gives three transfers, then terminal count
    load(16'h0100, 16'd2);
    xfer(16'h0100);
    chk(!tc_out, "R8 no tc mid block", int'(tc_out), 0);
    xfer(16'h0101);
    xfer(16'h0102);
    chk(tc_out, "R8 tc after last", int'(tc_out), 1);
    begin
      logic seen;
      seen = 1'b0;
      req_in = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        seen |= hold_req_out;
      end
      req_in = 1'b0;
      chk(!seen, "R8 stopped ignores request", int'(seen), 0);
    end

    // Reload clears tc; masked request ignored
    load(16'h2000, 16'd5);
    chk(!tc_out, "R10 load clears tc", int'(tc_out), 0);
    begin
      logic seen;
      seen = 1'b0;
      mask_in = 1'b1; req_in = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        seen |= hold_req_out;
      end
      chk(!seen, "R2 masked request ignored", int'(seen), 0);
      req_in = 1'b0; mask_in = 1'b0;
    end
    xfer(16'h2000);

    // Abort during setup: no update, same address next time
    exp_q.push_back(16'h2001);
    @(negedge clk);
    req_in = 1'b1; drop = 1'b0;
    do @(negedge clk); while (!ack_out);
    drop = 1'b1;
    @(negedge clk);
    chk(!ack_out && !bus_oe && mem_wr_n && io_rd_n, "R9 abort drops bus",
        int'({ack_out, bus_oe, mem_wr_n}), 1);
    // Grant withheld: request stands, nothing driven
    repeat (4) @(negedge clk);
    chk(hold_req_out, "R2 unmasked raises hrq", int'(hold_req_out), 1);
    chk(!ack_out && !bus_oe && mem_wr_n && io_rd_n, "R3 no drive without grant",
        int'({ack_out, bus_oe, mem_wr_n, io_rd_n}), 3);
    drop = 1'b0;
    do @(negedge clk); while (!ack_out);
    req_in = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R9 retried same address", exp_q.size(), 0);

    // Load during a transfer is ignored
    exp_q.push_back(16'h2002);
    @(negedge clk);
    req_in = 1'b1;
    do @(negedge clk); while (!ack_out);
    req_in = 1'b0;
    ld_en = 1'b1; ld_addr = 16'h7777; ld_cnt = 16'd0;
    @(negedge clk);
    ld_en = 1'b0;
    wait_idle();
    xfer(16'h2003);
    chk(!tc_out, "R10 busy load ignored", int'(tc_out), 0);

    // Address wrap
    load(16'hFFFF, 16'd1);
    xfer(16'hFFFF);
    xfer(16'h0000);
    chk(tc_out, "R7 wrap then tc", int'(tc_out), 1);
    chk(exp_q.size() == 0, "R7 all transfers seen", exp_q.size(), 0);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule